// File: doc/BRIEF.md
# Event State Buffer Load Controller

The block keeps two 2-bit coalescing states (PQ pairs) for each event queue descriptor. One is the notification state and the other is the escalation state. Software reaches these states only through 64-bit loads. Each descriptor owns an even/odd pair of pages in the address space: the even page acts on the notification state and the odd page on the escalation state. The low 12 bits of the address pick the operation:
- an end-of-interrupt,
- a plain read, or
- a forced set to one of the four PQ values.

The result goes back on the response bus one cycle after the request. A write-back strobe tells the descriptor storage about the new value, and it fires only when the stored value actually changes.

A separate event-trigger input runs the trigger rule on a descriptor's notification state. When that rule says to notify, the block raises a forward-notification output. A descriptor that is set to notify unconditionally forwards every trigger and its state is left alone. The `desc_valid_i` and `ucond_i` inputs carry per-descriptor flags that would otherwise live in the descriptor contents.

Top module: `esb_load_ctrl`

## Requirements
- R1: After reset every notification and escalation PQ pair is 01 (masked). No response, forward or write-back is active.
- R2: Address decoding works as follows. The descriptor index is `req_addr_i >> (PAGE_SHIFT+1)`. Address bit `PAGE_SHIFT` selects the page: 0 is notification and 1 is escalation. `req_addr_i[11:0]` is the page offset. `PAGE_SHIFT` is 12 or 16.
- R3: An accepted load at offset 0x000–0x7FF performs an end-of-interrupt on the selected PQ:
  - 00 becomes 00 and returns 0;
  - 10 becomes 00 and returns 0;
  - 11 becomes 10 and returns 1;
  - 01 stays 01 and returns 0.
  The result sits in data bit 0 and all other data bits are zero.
- R4: An accepted load at offset 0x800–0xBFF returns `{62'b0, P, Q}`, with P in bit 1 and Q in bit 0. The state does not change.
- R5: An accepted load at offset 0xC00–0xFFF sets the PQ to offset bits [9:8] and returns the old PQ in bits [1:0].
- R6: A store request is answered with `rsp_err_o`=1 and all-ones data. It changes no state.
- R7: A load whose size code `req_size_i` is not 3 is answered with error and all-ones data. It changes no state. The size code is log2 of the byte count, so 3 means 8 bytes.
- R8: A load to a descriptor index ≥ NUM_DESC, or to a descriptor whose `desc_valid_i` bit is 0, is answered with error and all-ones data. It changes no state.
- R9: `ld_wb_en_o` and `tr_wb_en_o` pulse one cycle after the operation, and only when the new PQ differs from the stored PQ. They carry the descriptor index and the new value.
- R10: A trigger on a valid, in-range descriptor that is not unconditional applies the trigger rule to its notification PQ:
  - 00 becomes 10 and notifies;
  - 10 becomes 11;
  - 11 stays 11;
  - 01 stays 01.
  `fwd_o` and `fwd_idx_o` are set one cycle later only when the rule notifies. A trigger to an invalid or out-of-range descriptor does nothing.
- R11: A trigger on a valid descriptor whose `ucond_i` bit is 1 always forwards and leaves its PQ unchanged.
- R12: A load and a trigger can hit the same notification PQ in the same cycle. In that case:
  - the load is applied first and the trigger rule runs on the load's result;
  - the response is the load's result;
  - only the trigger write-back channel reports, with the final value, and only if that value differs from the stored one.
- R13: `rsp_valid_o` is high exactly in the cycle after each cycle with `req_valid_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request |
| req_write_i | input | 1 | 1 = store (rejected), 0 = load |
| req_size_i | input | 2 | log2 of access size in bytes |
| req_addr_i | input | ADDR_W | Access address |
| desc_valid_i | input | NUM_DESC | Per-descriptor valid flag |
| ucond_i | input | NUM_DESC | Per-descriptor unconditional-notify flag |
| trig_valid_i | input | 1 | Event trigger |
| trig_idx_i | input | IDX_W | Triggered descriptor |
| rsp_valid_o | output | 1 | Response valid |
| rsp_err_o | output | 1 | Request rejected |
| rsp_data_o | output | 64 | Load result |
| fwd_o | output | 1 | Forward notification |
| fwd_idx_o | output | IDX_W | Descriptor forwarded |
| ld_wb_en_o | output | 1 | Load-path write-back strobe |
| ld_wb_idx_o | output | IDX_W | Load write-back descriptor |
| ld_wb_esc_o | output | 1 | Load write-back page (1 = escalation) |
| ld_wb_pq_o | output | 2 | Load write-back value |
| tr_wb_en_o | output | 1 | Trigger-path write-back strobe |
| tr_wb_idx_o | output | IDX_W | Trigger write-back descriptor |
| tr_wb_pq_o | output | 2 | Trigger write-back value (notification PQ) |

## Verification
A load and an event trigger can land on the same notification PQ in the same cycle. The merge order then decides the state, the forward and which write-back channel speaks. The bench sets up directed collisions from the 11 and 10 states, in which the trigger lands on the load's result and no write-back is due because the final value equals the stored one. Random stimulus then aims about half of all triggers at the index the load just decoded. Every response, forward and write-back strobe is compared against a bench model that applies the load first and the trigger second.

// File: rtl/esb_pkg.sv
package esb_pkg;
  typedef logic [1:0] pq_t;
  localparam pq_t PQ_MASKED = 2'b01;

  typedef enum logic [1:0] {OP_EOI = 2'd0, OP_GET = 2'd1, OP_SET = 2'd2} ld_op_e;

  localparam int OFF_W  = 12;
  localparam int DATA_W = 64;
endpackage

// File: rtl/esb_addr_decode.sv
module esb_addr_decode import esb_pkg::*; #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int NUM_DESC   = 12,
  parameter int IDX_W      = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              esc_o,
  output logic              in_range_o,
  output ld_op_e            op_o,
  output pq_t               set_val_o
);
  localparam int HI_W = ADDR_W - PAGE_SHIFT - 1;

  logic [HI_W-1:0]  hi;
  logic [OFF_W-1:0] off;

  assign hi         = addr_i[ADDR_W-1:PAGE_SHIFT+1];
  assign off        = addr_i[OFF_W-1:0];
  assign esc_o      = addr_i[PAGE_SHIFT];
  assign idx_o      = hi[IDX_W-1:0];
  assign in_range_o = (hi < HI_W'(NUM_DESC));
  assign set_val_o  = off[9:8];

  always_comb begin
    if (!off[11])              op_o = OP_EOI;
    else if (off[11:10] == 2'b10) op_o = OP_GET;
    else                       op_o = OP_SET;
  end
endmodule

// File: rtl/esb_load_alu.sv
module esb_load_alu import esb_pkg::*; (
  input  ld_op_e op_i,
  input  pq_t    set_val_i,
  input  pq_t    old_i,
  output pq_t    new_o,
  output pq_t    ret_o
);
  always_comb begin
    new_o = old_i;
    ret_o = old_i;
    unique case (op_i)
      OP_EOI: begin
        ret_o = {1'b0, old_i == 2'b11};
        unique case (old_i)
          2'b11:   new_o = 2'b10;
          2'b01:   new_o = 2'b01;
          default: new_o = 2'b00;
        endcase
      end
      OP_SET:  new_o = set_val_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/esb_trig_alu.sv
module esb_trig_alu import esb_pkg::*; (
  input  pq_t  old_i,
  output pq_t  new_o,
  output logic notify_o
);
  always_comb begin
    notify_o = (old_i == 2'b00);
    unique case (old_i)
      2'b00:   new_o = 2'b10;
      2'b10:   new_o = 2'b11;
      default: new_o = old_i;
    endcase
  end
endmodule

// File: rtl/esb_pq_bank.sv
module esb_pq_bank import esb_pkg::*; #(
  parameter int NUM_DESC = 12,
  parameter int IDX_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] a_idx_i,
  input  logic             a_esc_i,
  output pq_t              a_pq_o,
  input  logic [IDX_W-1:0] b_idx_i,
  output pq_t              b_pq_o,
  input  logic             wa_en_i,
  input  logic [IDX_W-1:0] wa_idx_i,
  input  logic             wa_esc_i,
  input  pq_t              wa_pq_i,
  input  logic             wb_en_i,
  input  logic [IDX_W-1:0] wb_idx_i,
  input  pq_t              wb_pq_i
);
  localparam logic [IDX_W:0] NUM_L = (IDX_W+1)'(NUM_DESC);

  pq_t notif[NUM_DESC];
  pq_t escal[NUM_DESC];

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_desc
    localparam logic [IDX_W-1:0] ME = IDX_W'(g);
    pq_t n_q, e_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        n_q <= PQ_MASKED;
        e_q <= PQ_MASKED;
      end else begin
        // trigger path carries the merged value when both hit this pair
        if (wb_en_i && wb_idx_i == ME)                     n_q <= wb_pq_i;
        else if (wa_en_i && !wa_esc_i && wa_idx_i == ME)   n_q <= wa_pq_i;
        if (wa_en_i && wa_esc_i && wa_idx_i == ME)         e_q <= wa_pq_i;
      end
    end
    assign notif[g] = n_q;
    assign escal[g] = e_q;
  end

  always_comb begin
    a_pq_o = PQ_MASKED;
    if ({1'b0, a_idx_i} < NUM_L) a_pq_o = a_esc_i ? escal[a_idx_i] : notif[a_idx_i];
  end

  always_comb begin
    b_pq_o = PQ_MASKED;
    if ({1'b0, b_idx_i} < NUM_L) b_pq_o = notif[b_idx_i];
  end
endmodule

// File: rtl/esb_load_ctrl.sv
module esb_load_ctrl import esb_pkg::*; #(
  parameter int NUM_DESC   = 12,
  parameter int PAGE_SHIFT = 12,
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic                req_write_i,
  input  logic [1:0]          req_size_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [NUM_DESC-1:0] desc_valid_i,
  input  logic [NUM_DESC-1:0] ucond_i,
  input  logic                trig_valid_i,
  input  logic [IDX_W-1:0]    trig_idx_i,
  output logic                rsp_valid_o,
  output logic                rsp_err_o,
  output logic [63:0]         rsp_data_o,
  output logic                fwd_o,
  output logic [IDX_W-1:0]    fwd_idx_o,
  output logic                ld_wb_en_o,
  output logic [IDX_W-1:0]    ld_wb_idx_o,
  output logic                ld_wb_esc_o,
  output logic [1:0]          ld_wb_pq_o,
  output logic                tr_wb_en_o,
  output logic [IDX_W-1:0]    tr_wb_idx_o,
  output logic [1:0]          tr_wb_pq_o
);
  localparam logic [IDX_W:0] NUM_L     = (IDX_W+1)'(NUM_DESC);
  localparam logic [1:0]     SIZE_DW   = 2'd3;

  logic [IDX_W-1:0] ld_idx;
  logic             ld_esc, ld_in_range, ld_ok;
  ld_op_e           ld_op;
  pq_t              ld_set_val, ld_old, ld_new, ld_ret;

  logic             tr_ok, tr_ucond, tr_notify, collide;
  pq_t              tr_stored, tr_base, tr_new;

  esb_addr_decode #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .NUM_DESC(NUM_DESC), .IDX_W(IDX_W)
  ) u_dec (
    .addr_i(req_addr_i), .idx_o(ld_idx), .esc_o(ld_esc), .in_range_o(ld_in_range),
    .op_o(ld_op), .set_val_o(ld_set_val)
  );

  esb_load_alu u_ld_alu (
    .op_i(ld_op), .set_val_i(ld_set_val), .old_i(ld_old), .new_o(ld_new), .ret_o(ld_ret)
  );

  esb_trig_alu u_tr_alu (.old_i(tr_base), .new_o(tr_new), .notify_o(tr_notify));

  logic wa_en, wb_en;

  esb_pq_bank #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W)) u_bank (
    .clk_i, .rst_ni,
    .a_idx_i(ld_idx), .a_esc_i(ld_esc), .a_pq_o(ld_old),
    .b_idx_i(trig_idx_i), .b_pq_o(tr_stored),
    .wa_en_i(wa_en), .wa_idx_i(ld_idx), .wa_esc_i(ld_esc), .wa_pq_i(ld_new),
    .wb_en_i(wb_en), .wb_idx_i(trig_idx_i), .wb_pq_i(tr_new)
  );

  assign ld_ok = req_valid_i && !req_write_i && (req_size_i == SIZE_DW) &&
                 ld_in_range && desc_valid_i[ld_idx];

  assign tr_ok    = trig_valid_i && ({1'b0, trig_idx_i} < NUM_L) && desc_valid_i[trig_idx_i];
  assign tr_ucond = ucond_i[trig_idx_i];
  // same notification pair: load result feeds the trigger rule
  assign collide  = ld_ok && !ld_esc && tr_ok && !tr_ucond && (ld_idx == trig_idx_i);
  assign tr_base  = collide ? ld_new : tr_stored;

  assign wa_en = ld_ok && (ld_new != ld_old) && !collide;
  assign wb_en = tr_ok && !tr_ucond && (tr_new != tr_stored);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_data_o  <= '0;
      fwd_o       <= 1'b0;
      fwd_idx_o   <= '0;
      ld_wb_en_o  <= 1'b0;
      ld_wb_idx_o <= '0;
      ld_wb_esc_o <= 1'b0;
      ld_wb_pq_o  <= '0;
      tr_wb_en_o  <= 1'b0;
      tr_wb_idx_o <= '0;
      tr_wb_pq_o  <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_err_o   <= req_valid_i && !ld_ok;
      rsp_data_o  <= ld_ok ? {{(DATA_W-2){1'b0}}, ld_ret} : '1;
      fwd_o       <= tr_ok && (tr_ucond || tr_notify);
      fwd_idx_o   <= trig_idx_i;
      ld_wb_en_o  <= wa_en;
      ld_wb_idx_o <= ld_idx;
      ld_wb_esc_o <= ld_esc;
      ld_wb_pq_o  <= ld_new;
      tr_wb_en_o  <= wb_en;
      tr_wb_idx_o <= trig_idx_i;
      tr_wb_pq_o  <= tr_new;
    end
  end
endmodule

// File: rtl/esb_load_ctrl_sva.sv
module esb_load_ctrl_sva import esb_pkg::*; #(
  parameter int IDX_W  = 4,
  parameter int ADDR_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_write_i,
  input logic [1:0]       req_size_i,
  input logic             trig_valid_i,
  input logic             rsp_valid_o,
  input logic             rsp_err_o,
  input logic [63:0]      rsp_data_o,
  input logic             fwd_o,
  input logic             ld_wb_en_o,
  input logic [IDX_W-1:0] ld_wb_idx_o,
  input logic             ld_wb_esc_o,
  input logic [1:0]       ld_wb_pq_o,
  input logic             tr_wb_en_o,
  input logic [IDX_W-1:0] tr_wb_idx_o,
  input logic             ld_ok,
  input ld_op_e           ld_op,
  input logic [1:0]       ld_old
);
  assert_rsp_follows_req_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  assert_no_spurious_rsp_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  assert_store_rejected_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i) |=> (rsp_err_o && (rsp_data_o == '1) && !ld_wb_en_o));
  assert_bad_size_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && req_size_i != 2'd3) |=> (rsp_err_o && !ld_wb_en_o));
  assert_wb_on_change_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_wb_en_o |-> (ld_wb_pq_o != $past(ld_old)));
  assert_get_keeps_state_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_ok && ld_op == OP_GET) |=> (!ld_wb_en_o && rsp_data_o[63:2] == '0));
  assert_eoi_result_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_ok && ld_op == OP_EOI) |=> (!rsp_err_o && rsp_data_o[63:1] == '0));
  assert_fwd_needs_trig_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_o |-> $past(trig_valid_i));
  assert_single_wb_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ld_wb_en_o && tr_wb_en_o && !ld_wb_esc_o && ld_wb_idx_o == tr_wb_idx_o));
endmodule

bind esb_load_ctrl esb_load_ctrl_sva #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_write_i(req_write_i),
  .req_size_i(req_size_i), .trig_valid_i(trig_valid_i), .rsp_valid_o(rsp_valid_o),
  .rsp_err_o(rsp_err_o), .rsp_data_o(rsp_data_o), .fwd_o(fwd_o),
  .ld_wb_en_o(ld_wb_en_o), .ld_wb_idx_o(ld_wb_idx_o), .ld_wb_esc_o(ld_wb_esc_o),
  .ld_wb_pq_o(ld_wb_pq_o), .tr_wb_en_o(tr_wb_en_o), .tr_wb_idx_o(tr_wb_idx_o),
  .ld_ok(ld_ok), .ld_op(ld_op), .ld_old(ld_old)
);

// File: tb/esb_load_ctrl_test.sv
module esb_load_ctrl_test;
  localparam int ND = 12;
  localparam int PS = 12;
  localparam int AW = 32;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]    req_size = 2'd3;
  logic [AW-1:0] req_addr = '0;
  logic [ND-1:0] dv = 12'b1111_1101_1111;   // descriptor 5 invalid
  logic [ND-1:0] uc = 12'b0000_0000_1000;   // descriptor 3 unconditional
  logic          trig_valid = 1'b0;
  logic [IW-1:0] trig_idx = '0;
  logic          rsp_valid, rsp_err, fwd, ld_wb_en, ld_wb_esc, tr_wb_en;
  logic [63:0]   rsp_data;
  logic [IW-1:0] fwd_idx, ld_wb_idx, tr_wb_idx;
  logic [1:0]    ld_wb_pq, tr_wb_pq;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;
  logic [1:0] mn[ND];
  logic [1:0] me[ND];

  always #5 clk = ~clk;

  esb_load_ctrl #(.NUM_DESC(ND), .PAGE_SHIFT(PS), .ADDR_W(AW), .IDX_W(IW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_size_i(req_size), .req_addr_i(req_addr), .desc_valid_i(dv), .ucond_i(uc),
    .trig_valid_i(trig_valid), .trig_idx_i(trig_idx), .rsp_valid_o(rsp_valid),
    .rsp_err_o(rsp_err), .rsp_data_o(rsp_data), .fwd_o(fwd), .fwd_idx_o(fwd_idx),
    .ld_wb_en_o(ld_wb_en), .ld_wb_idx_o(ld_wb_idx), .ld_wb_esc_o(ld_wb_esc),
    .ld_wb_pq_o(ld_wb_pq), .tr_wb_en_o(tr_wb_en), .tr_wb_idx_o(tr_wb_idx),
    .tr_wb_pq_o(tr_wb_pq)
  );

  function automatic logic [1:0] f_trig(input logic [1:0] s);
    case (s)
      2'b00: return 2'b10;
      2'b10: return 2'b11;
      default: return s;
    endcase
  endfunction

  function automatic logic [1:0] f_eoi(input logic [1:0] s);
    if (s == 2'b11) return 2'b10;
    if (s == 2'b01) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [AW-1:0] mk_addr(input int idx, input bit esc, input int off);
    return (AW'(idx) << (PS + 1)) | (AW'(esc) << PS) | AW'(off & 32'hFFF);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic lv, input logic lw, input logic [1:0] sz,
                      input logic [AW-1:0] addr, input logic tv,
                      input logic [IW-1:0] tix, input string tag);
    int hi, idx, off, ti;
    bit esc, lok, tok, tuc, coll, e_fwd, e_ldwb, e_trwb;
    logic [1:0] old, nw, ret, tsto, tbase, tnew;
    logic [63:0] e_data;
    string rtag;
    hi  = int'(addr >> (PS + 1));
    idx = hi % 16;
    esc = addr[PS];
    off = int'(addr[11:0]);
    ti  = int'(tix);
    lok = lv && !lw && sz == 2'd3 && hi < ND && dv[idx];
    old = 2'b01; nw = 2'b01; ret = 2'b00;
    if (lok) begin
      old = esc ? me[idx] : mn[idx];
      if (off < 'h800) begin nw = f_eoi(old); ret = {1'b0, old == 2'b11}; rtag = "R3"; end
      else if (off < 'hC00) begin nw = old; ret = old; rtag = "R4"; end
      else begin nw = 2'((off >> 8) & 3); ret = old; rtag = "R5"; end
    end else if (lw) rtag = "R6";
    else if (sz != 2'd3) rtag = "R7";
    else rtag = "R8";
    if (tag != "") rtag = tag;
    tok  = tv && ti < ND && dv[ti];
    tuc  = tok && uc[ti];
    coll = lok && !esc && tok && !tuc && idx == ti;
    tsto = (ti < ND) ? mn[ti] : 2'b01;
    tbase = coll ? nw : tsto;
    tnew  = f_trig(tbase);
    e_fwd  = tok && (tuc || tbase == 2'b00);
    e_ldwb = lok && nw != old && !coll;
    e_trwb = tok && !tuc && tnew != tsto;
    e_data = lok ? {62'b0, ret} : '1;

    @(negedge clk);
    req_valid = lv; req_write = lw; req_size = sz; req_addr = addr;
    trig_valid = tv; trig_idx = tix;
    @(posedge clk);
    #1;
    chk(rsp_valid == lv, "R13 rsp_valid", 64'(rsp_valid), 64'(lv));
    if (lv) begin
      chk(rsp_err == !lok, {rtag, " rsp_err"}, 64'(rsp_err), 64'(!lok));
      chk(rsp_data == e_data, {rtag, " rsp_data"}, rsp_data, e_data);
    end
    chk(fwd == e_fwd, coll ? "R12 fwd" : (tuc ? "R11 fwd" : "R10 fwd"),
        64'(fwd), 64'(e_fwd));
    if (e_fwd) chk(fwd_idx == tix, "R10 fwd_idx", 64'(fwd_idx), 64'(tix));
    chk(ld_wb_en == e_ldwb, coll ? "R12 ld_wb_en" : "R9 ld_wb_en",
        64'(ld_wb_en), 64'(e_ldwb));
    if (e_ldwb)
      chk({ld_wb_idx, ld_wb_esc, ld_wb_pq} == {4'(idx), esc, nw}, "R9 ld_wb fields",
          64'({ld_wb_idx, ld_wb_esc, ld_wb_pq}), 64'({4'(idx), esc, nw}));
    chk(tr_wb_en == e_trwb, coll ? "R12 tr_wb_en" : "R9 tr_wb_en",
        64'(tr_wb_en), 64'(e_trwb));
    if (e_trwb)
      chk({tr_wb_idx, tr_wb_pq} == {tix, tnew}, "R10 tr_wb fields",
          64'({tr_wb_idx, tr_wb_pq}), 64'({tix, tnew}));
    if (lok && !coll) begin
      if (esc) me[idx] = nw; else mn[idx] = nw;
    end
    if (tok && !tuc) mn[ti] = tnew;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 0; req_write = 0; req_size = 2'd3; trig_valid = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240607);
    for (int i = 0; i < ND; i++) begin mn[i] = 2'b01; me[i] = 2'b01; end
    repeat (3) @(posedge clk);
    #1;
    chk(!rsp_valid && !fwd && !ld_wb_en && !tr_wb_en, "R1 idle outputs",
        64'({rsp_valid, fwd, ld_wb_en, tr_wb_en}), 64'(0));
    @(negedge clk); rst_n = 1'b1;

    // R1: every pair reads 01 after reset
    for (int d = 0; d < ND; d++)
      for (int p = 0; p < 2; p++)
        if (d != 5) step(1, 0, 3, mk_addr(d, p[0], 'h800), 0, 0, "R1");

    // R2: page select and index decode
    step(1, 0, 3, mk_addr(7, 1, 'hF00), 0, 0, "R2");
    step(1, 0, 3, mk_addr(7, 0, 'h9F8), 0, 0, "R2");
    step(1, 0, 3, mk_addr(7, 1, 'h800), 0, 0, "R2");

    // R10 / R3 sequence on descriptor 0
    step(1, 0, 3, mk_addr(0, 0, 'hC00), 0, 0, "");
    step(0, 0, 3, 0, 1, 4'd0, "");
    step(0, 0, 3, 0, 1, 4'd0, "");
    step(0, 0, 3, 0, 1, 4'd0, "");
    step(1, 0, 3, mk_addr(0, 0, 'h000), 0, 0, "");
    step(1, 0, 3, mk_addr(0, 0, 'h7F8), 0, 0, "");
    step(1, 0, 3, mk_addr(0, 0, 'h400), 0, 0, "");

    // R11 unconditional, R8 invalid / out of range
    step(0, 0, 3, 0, 1, 4'd3, "");
    step(1, 0, 3, mk_addr(5, 0, 'hD00), 1, 4'd5, "");
    step(1, 0, 3, mk_addr(13, 0, 'h800), 1, 4'd14, "");
    // R6 store, R7 size
    step(1, 1, 3, mk_addr(2, 0, 'hC00), 0, 0, "");
    step(1, 0, 2, mk_addr(2, 0, 'hC00), 0, 0, "");
    step(1, 0, 3, mk_addr(2, 0, 'h800), 0, 0, "");

    // R12 collisions
    step(1, 0, 3, mk_addr(1, 0, 'hF00), 0, 0, "");
    step(1, 0, 3, mk_addr(1, 0, 'h000), 1, 4'd1, "R12");
    step(1, 0, 3, mk_addr(1, 0, 'hE00), 0, 0, "");
    step(1, 0, 3, mk_addr(1, 0, 'h010), 1, 4'd1, "R12");
    step(1, 0, 3, mk_addr(1, 0, 'h800), 1, 4'd1, "R12");

    for (int n = 0; n < 4000; n++) begin
      int idx, cat, off;
      bit lv, lw, tv, esc;
      logic [1:0] sz;
      logic [IW-1:0] tix;
      idx = $urandom % 16;
      esc = $urandom % 2;
      cat = $urandom % 4;
      off = (cat == 0) ? $urandom % 'h800 :
            (cat == 1) ? 'h800 + $urandom % 'h400 : 'hC00 + $urandom % 'h400;
      lv = ($urandom % 8) != 0;
      lw = ($urandom % 16) == 0;
      sz = (($urandom % 16) == 1) ? 2'($urandom % 3) : 2'd3;
      tv = $urandom % 2;
      tix = (($urandom % 2) == 0) ? IW'(idx) : IW'($urandom % 16);
      step(lv, lw, sz, mk_addr(idx, esc, off), tv, tix, "");
    end
    idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule